// File: doc/BRIEF.md
# Two-Wire Control Bus Slave with Triggered Shadow Registers

This block listens on a two-wire control bus (one clock line, one data line, both driven by the bus master) and decodes register-write and masked-write transactions sent to its own slave ID. It oversamples both bus lines with its own system clock. It finds the start condition and shifts in frames on falling bus-clock edges. It checks odd parity on every frame and then updates a small register file. That file holds a switch control word and a trigger configuration register.

The switch control word can be double-buffered. While any trigger is enabled, writes to it land in a shadow copy and leave the driven output alone. The copy moves to the output only when a 1 is written to the fire bit of an enabled trigger. With no trigger enabled, writes go straight through and the shadow follows. A strap input picks one of two slave IDs, so two copies of the block can share one bus.

Top module: `swbus_trig_slave`

## Requirements
- R1: A transaction starts only after a start condition, which is the data line rising and then falling while the bus clock stays low. After that, bits are sampled on falling bus-clock edges, most significant bit first. Bus activity without a start condition changes nothing.
- R2: The slave ID is 4'h7 when `id_sel_i` is high and 4'h6 when it is low. A transaction whose first 4 bits carry any other ID changes no state.
- R3: A plain write is a 13-bit command frame {ID[3:0], 3'b010, addr[4:0], parity} followed by one 9-bit data frame {data[7:0], parity}. The data replaces the whole addressed register.
- R4: A masked write is a command frame with command byte 8'h19, followed by three 9-bit frames: address, mask, then data. Each result bit is the old bit where the mask bit is 1 and the data bit where the mask bit is 0.
- R5: Every frame carries odd parity: the count of 1s in the frame, parity bit included, is odd. A parity error in any frame drops the whole transaction, and no register, enable or shadow changes.
- R6: Reset clears the switch control output, its shadow and all trigger enables to zero.
- R7: The trigger register sits at address 8'h1C. Bit 3+k enables trigger k (k = 0..2) and is stored. Bits 2:0 are fire strobes and are never stored. `trig_en_o[k]` shows the enable of trigger k.
- R8: With no trigger enabled, a write to the switch control register at address 8'h01 appears on `sw_ctrl_o`, and the shadow takes the same value.
- R9: With any trigger enabled, a write to address 8'h01 updates only the shadow, and `sw_ctrl_o` holds its value. A masked write then merges into the shadow value.
- R10: Writing 1 to fire bit k copies the shadow to `sw_ctrl_o` if trigger k was enabled before that write. A fire bit on a disabled trigger has no effect.
- R11: Writes to any address other than 8'h01 and 8'h1C, and command bytes other than the two write forms, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Bus clock line from the master (asynchronous) |
| sdata_i | input | 1 | Bus data line from the master (asynchronous) |
| id_sel_i | input | 1 | Strap picking slave ID 4'h7 (high) or 4'h6 (low) |
| sw_ctrl_o | output | 8 | Active switch control word |
| trig_en_o | output | 3 | Stored trigger enables, bit k for trigger k |

## Verification
The assertions assume that the decoder issues at most one register request per transaction, as a single-cycle pulse. They also assume that every register change follows such a request by one cycle, so that state holds steady between transactions. The bus model assumes that the data line changes only while the bus clock is high, except during the start and park phases. It also assumes that each bus-clock phase spans several system clocks and that the ID strap stays fixed within a transaction. The bench's bit driver meets these by holding each bus-clock phase for five system clocks and moving data two clocks into the high phase. It changes the strap only between transactions.

// File: rtl/swbus_pkg.sv
package swbus_pkg;
  localparam int unsigned ID_W   = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_AW = 5;
  localparam logic [2:0] OP_WRITE  = 3'b010;
  localparam logic [7:0] OP_MASKED = 8'h19;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_ARMED,
    RX_CMD,
    RX_DATA
  } rx_state_e;

  typedef enum logic {
    KIND_PLAIN,
    KIND_MASKED
  } wr_kind_e;
endpackage

// File: rtl/swbus_sync.sv
module swbus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic sclk_lvl,
  output logic sdata_lvl,
  output logic sclk_fall,
  output logic sdata_rise,
  output logic sdata_fall
);
  localparam int unsigned NSIG = 2;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] lvl;
  logic [NSIG-1:0] last;

  assign raw = {sdata_i, sclk_i};

  for (genvar i = 0; i < NSIG; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '0;
        last[i] <= 1'b0;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[i]};
        last[i] <= chain[STAGES-1];
      end
    end
    assign lvl[i] = chain[STAGES-1];
  end

  assign sclk_lvl   = lvl[0];
  assign sdata_lvl  = lvl[1];
  assign sclk_fall  = last[0] & ~lvl[0];
  assign sdata_rise = ~last[1] & lvl[1];
  assign sdata_fall = last[1] & ~lvl[1];
endmodule

// File: rtl/swbus_frame_rx.sv
module swbus_frame_rx
  import swbus_pkg::*;
#(
  parameter int unsigned       ID_WIDTH = ID_W,
  parameter int unsigned       DATA_W   = BYTE_W,
  parameter logic [ID_W-1:0]   ID_BASE  = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_sel_i,
  input  logic              sclk_lvl,
  input  logic              sdata_lvl,
  input  logic              sclk_fall,
  input  logic              sdata_rise,
  input  logic              sdata_fall,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_mask_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CMD_W = ID_WIDTH + DATA_W + 1;
  localparam int unsigned DAT_W = DATA_W + 1;
  localparam int unsigned CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DAT_W - 1);

  rx_state_e         state;
  wr_kind_e          kind;
  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        frames_left;
  logic [CMD_W-2:0]  shreg;
  logic              par;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;

  logic [CMD_W-1:0]    word;
  logic [ID_WIDTH-1:0] my_id;
  logic [ID_WIDTH-1:0] sa_in;
  logic [DATA_W-1:0]   byte_in;
  logic                last_bit;
  logic                par_ok;
  logic                in_frame;

  assign word     = {shreg, sdata_lvl};
  assign my_id    = {ID_BASE[ID_WIDTH-1:1], id_sel_i};
  assign sa_in    = word[CMD_W-1 -: ID_WIDTH];
  assign byte_in  = word[DATA_W:1];
  assign in_frame = (state == RX_CMD) || (state == RX_DATA);
  assign last_bit = (state == RX_CMD) ? (bit_cnt == CMD_LAST) : (bit_cnt == DAT_LAST);
  assign par_ok   = par ^ sdata_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= RX_IDLE;
      kind        <= KIND_PLAIN;
      bit_cnt     <= '0;
      frames_left <= '0;
      shreg       <= '0;
      par         <= 1'b0;
      addr_q      <= '0;
      mask_q      <= '0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_mask_o   <= '0;
      wr_data_o   <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (sdata_rise && !sclk_lvl) begin
        state <= RX_ARMED;
      end else if (sdata_fall && !sclk_lvl && state == RX_ARMED) begin
        state   <= RX_CMD;
        bit_cnt <= '0;
        par     <= 1'b0;
      end else if (sclk_fall && state == RX_ARMED) begin
        state <= RX_IDLE;
      end else if (sclk_fall && in_frame) begin
        shreg   <= word[CMD_W-2:0];
        par     <= par ^ sdata_lvl;
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          bit_cnt <= '0;
          par     <= 1'b0;
          if (!par_ok) begin
            state <= RX_IDLE;
          end else if (state == RX_CMD) begin
            if (sa_in != my_id) begin
              state <= RX_IDLE;
            end else if (byte_in[DATA_W-1:REG_AW] == OP_WRITE) begin
              kind        <= KIND_PLAIN;
              addr_q      <= DATA_W'(byte_in[REG_AW-1:0]);
              frames_left <= 2'd1;
              state       <= RX_DATA;
            end else if (byte_in == OP_MASKED) begin
              kind        <= KIND_MASKED;
              frames_left <= 2'd3;
              state       <= RX_DATA;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            frames_left <= frames_left - 1'b1;
            if (frames_left == 2'd3) begin
              addr_q <= byte_in;
            end else if (frames_left == 2'd2) begin
              mask_q <= byte_in;
            end else begin
              wr_valid_o <= 1'b1;
              wr_addr_o  <= addr_q;
              wr_mask_o  <= (kind == KIND_MASKED) ? mask_q : '0;
              wr_data_o  <= byte_in;
              state      <= RX_IDLE;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/swbus_trig_regs.sv
module swbus_trig_regs
  import swbus_pkg::*;
#(
  parameter int unsigned       DATA_W    = BYTE_W,
  parameter int unsigned       NUM_TRIG  = 3,
  parameter int unsigned       EN_LSB    = 3,
  parameter logic [BYTE_W-1:0] CTRL_ADDR = 8'h01,
  parameter logic [BYTE_W-1:0] TRIG_ADDR = 8'h1C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [DATA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_mask,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic [NUM_TRIG-1:0] trig_en_o
);
  localparam int unsigned EN_MSB = EN_LSB + NUM_TRIG - 1;

  logic [DATA_W-1:0]   active_q;
  logic [DATA_W-1:0]   shadow_q;
  logic [NUM_TRIG-1:0] en_q;
  logic                any_en;
  logic [DATA_W-1:0]   ctrl_base;
  logic [DATA_W-1:0]   ctrl_new;
  logic [DATA_W-1:0]   trig_cur;
  logic [DATA_W-1:0]   trig_new;
  logic [NUM_TRIG-1:0] fire;

  assign any_en    = |en_q;
  assign ctrl_base = any_en ? shadow_q : active_q;
  assign ctrl_new  = (ctrl_base & wr_mask) | (wr_data & ~wr_mask);

  always_comb begin
    trig_cur = '0;
    trig_cur[EN_MSB:EN_LSB] = en_q;
  end

  assign trig_new = (trig_cur & wr_mask) | (wr_data & ~wr_mask);

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_fire
    assign fire[k] = trig_new[k] & en_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      shadow_q <= '0;
      en_q     <= '0;
    end else if (wr_valid) begin
      if (wr_addr == CTRL_ADDR) begin
        shadow_q <= ctrl_new;
        if (!any_en) begin
          active_q <= ctrl_new;
        end
      end else if (wr_addr == TRIG_ADDR) begin
        en_q <= trig_new[EN_MSB:EN_LSB];
        if (|fire) begin
          active_q <= shadow_q;
        end
      end
    end
  end

  assign ctrl_o    = active_q;
  assign trig_en_o = en_q;
endmodule

// File: rtl/swbus_trig_slave.sv
module swbus_trig_slave
  import swbus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_TRIG    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_i,
  input  logic                sdata_i,
  input  logic                id_sel_i,
  output logic [BYTE_W-1:0]   sw_ctrl_o,
  output logic [NUM_TRIG-1:0] trig_en_o
);
  logic              sclk_lvl;
  logic              sdata_lvl;
  logic              sclk_fall;
  logic              sdata_rise;
  logic              sdata_fall;
  logic              wr_valid;
  logic [BYTE_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_mask;
  logic [BYTE_W-1:0] wr_data;

  swbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk_i),
    .sdata_i   (sdata_i),
    .sclk_lvl  (sclk_lvl),
    .sdata_lvl (sdata_lvl),
    .sclk_fall (sclk_fall),
    .sdata_rise(sdata_rise),
    .sdata_fall(sdata_fall)
  );

  swbus_frame_rx #(.ID_WIDTH(ID_W), .DATA_W(BYTE_W), .ID_BASE(4'h6)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_sel_i  (id_sel_i),
    .sclk_lvl  (sclk_lvl),
    .sdata_lvl (sdata_lvl),
    .sclk_fall (sclk_fall),
    .sdata_rise(sdata_rise),
    .sdata_fall(sdata_fall),
    .wr_valid_o(wr_valid),
    .wr_addr_o (wr_addr),
    .wr_mask_o (wr_mask),
    .wr_data_o (wr_data)
  );

  swbus_trig_regs #(.DATA_W(BYTE_W), .NUM_TRIG(NUM_TRIG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data),
    .ctrl_o   (sw_ctrl_o),
    .trig_en_o(trig_en_o)
  );
endmodule

// File: rtl/swbus_trig_slave_chk.sv
module swbus_trig_slave_chk #(
  parameter int unsigned     W         = 8,
  parameter int unsigned     NT        = 3,
  parameter logic [W-1:0]    CTRL_ADDR = 8'h01,
  parameter logic [W-1:0]    TRIG_ADDR = 8'h1C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [W-1:0]  wr_addr,
  input logic [W-1:0]  wr_mask,
  input logic [W-1:0]  wr_data,
  input logic [W-1:0]  sw_ctrl_o,
  input logic [NT-1:0] trig_en_o
);
  AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R1

  AST_CTRL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(sw_ctrl_o)); // R5

  AST_EN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(trig_en_o)); // R11

  AST_DIRECT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == CTRL_ADDR && trig_en_o == '0) |=>
      sw_ctrl_o == (($past(sw_ctrl_o) & $past(wr_mask)) | ($past(wr_data) & ~$past(wr_mask)))); // R8

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == CTRL_ADDR && trig_en_o != '0) |=> $stable(sw_ctrl_o)); // R9

  AST_FIRE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == TRIG_ADDR && trig_en_o == '0) |=> $stable(sw_ctrl_o)); // R10
endmodule

bind swbus_trig_slave swbus_trig_slave_chk #(.W(8), .NT(NUM_TRIG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .wr_mask  (wr_mask),
  .wr_data  (wr_data),
  .sw_ctrl_o(sw_ctrl_o),
  .trig_en_o(trig_en_o)
);

// File: tb/tb_swbus_trig_slave.sv
module tb_swbus_trig_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       id_sel = 1'b0;
  logic [7:0] sw_ctrl;
  logic [2:0] trig_en;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  localparam logic [3:0] SA_LO = 4'h6;
  localparam logic [3:0] SA_HI = 4'h7;

  always #4 clk = ~clk;

  swbus_trig_slave dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_i   (sclk),
    .sdata_i  (sdata),
    .id_sel_i (id_sel),
    .sw_ctrl_o(sw_ctrl),
    .trig_en_o(trig_en)
  );

  task automatic clk_wait(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic oddp(logic [11:0] v);
    return ~(^v);
  endfunction

  task automatic send_bit(logic b);
    sclk = 1'b1;
    clk_wait(2);
    sdata = b;
    clk_wait(3);
    sclk = 1'b0;
    clk_wait(5);
  endtask

  task automatic send_bits(logic [12:0] w, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic ssc();
    sclk = 1'b0;
    clk_wait(5);
    sdata = 1'b1;
    clk_wait(8);
    sdata = 1'b0;
    clk_wait(8);
  endtask

  task automatic bpc();
    sdata = 1'b0;
    clk_wait(2);
    sclk = 1'b1;
    clk_wait(5);
    sclk = 1'b0;
    clk_wait(12);
  endtask

  task automatic send_cmd(logic [3:0] sa, logic [7:0] cmd, logic bad);
    logic [11:0] b;
    b = {sa, cmd};
    send_bits({b, oddp(b) ^ bad}, 13);
  endtask

  task automatic send_byte(logic [7:0] d, logic bad);
    send_bits({4'b0, d, oddp({4'b0, d}) ^ bad}, 9);
  endtask

  task automatic plain_wr(logic [3:0] sa, logic [4:0] a, logic [7:0] d, int bad);
    ssc();
    send_cmd(sa, {3'b010, a}, bad == 0);
    send_byte(d, bad == 1);
    bpc();
  endtask

  task automatic masked_wr(logic [3:0] sa, logic [7:0] a, logic [7:0] m, logic [7:0] d, int bad);
    ssc();
    send_cmd(sa, 8'h19, bad == 0);
    send_byte(a, bad == 1);
    send_byte(m, bad == 2);
    send_byte(d, bad == 3);
    bpc();
  endtask

  task automatic t_reset();
    check("R6 reset sw_ctrl", sw_ctrl, 8'h00);
    check("R6 reset trig_en", {5'b0, trig_en}, 8'h00);
  endtask

  task automatic t_direct();
    masked_wr(SA_LO, 8'h01, 8'h00, 8'hA5, -1);
    check("R8 masked full write direct", sw_ctrl, 8'hA5);
    masked_wr(SA_LO, 8'h01, 8'hF0, 8'h3C, -1);
    check("R4 masked merge", sw_ctrl, 8'hAC);
    plain_wr(SA_LO, 5'h01, 8'h5A, -1);
    check("R3 plain write", sw_ctrl, 8'h5A);
  endtask

  task automatic t_id();
    plain_wr(SA_HI, 5'h01, 8'hEE, -1);
    check("R2 foreign id ignored", sw_ctrl, 8'h5A);
    id_sel = 1'b1;
    clk_wait(4);
    plain_wr(SA_HI, 5'h01, 8'h33, -1);
    check("R2 strap high id 7", sw_ctrl, 8'h33);
    plain_wr(SA_LO, 5'h01, 8'h44, -1);
    check("R2 id 6 ignored when strap high", sw_ctrl, 8'h33);
    id_sel = 1'b0;
    clk_wait(4);
  endtask

  task automatic t_parity_start();
    plain_wr(SA_LO, 5'h01, 8'h99, 0);
    check("R5 bad command parity", sw_ctrl, 8'h33);
    masked_wr(SA_LO, 8'h01, 8'h00, 8'h99, 3);
    check("R5 bad data parity", sw_ctrl, 8'h33);
    masked_wr(SA_LO, 8'h01, 8'h00, 8'h99, 2);
    check("R5 bad mask parity", sw_ctrl, 8'h33);
    send_cmd(SA_LO, {3'b010, 5'h01}, 1'b0);
    send_byte(8'h77, 1'b0);
    bpc();
    check("R1 no start condition", sw_ctrl, 8'h33);
  endtask

  task automatic t_trigger();
    plain_wr(SA_LO, 5'h1C, 8'h08, -1);
    check("R7 enable trigger 0", {5'b0, trig_en}, 8'h01);
    masked_wr(SA_LO, 8'h01, 8'h00, 8'hC3, -1);
    check("R9 shadowed write holds output", sw_ctrl, 8'h33);
    plain_wr(SA_LO, 5'h1C, 8'h09, -1);
    check("R10 fire trigger 0", sw_ctrl, 8'hC3);
    check("R7 fire bit not stored", {5'b0, trig_en}, 8'h01);
    masked_wr(SA_LO, 8'h01, 8'h0F, 8'h50, -1);
    check("R9 masked into shadow holds output", sw_ctrl, 8'hC3);
    plain_wr(SA_LO, 5'h1C, 8'h09, -1);
    check("R4 R10 shadow merge committed", sw_ctrl, 8'h53);
    masked_wr(SA_LO, 8'h01, 8'h00, 8'h11, -1);
    plain_wr(SA_LO, 5'h1C, 8'h0A, -1);
    check("R10 fire on disabled trigger 1", sw_ctrl, 8'h53);
    plain_wr(SA_LO, 5'h1C, 8'h09, -1);
    check("R10 pending shadow commit", sw_ctrl, 8'h11);
    plain_wr(SA_LO, 5'h1C, 8'h00, -1);
    check("R7 disable triggers", {5'b0, trig_en}, 8'h00);
    masked_wr(SA_LO, 8'h01, 8'h00, 8'h77, -1);
    check("R8 direct after disable", sw_ctrl, 8'h77);
    plain_wr(SA_LO, 5'h1C, 8'h21, -1);
    check("R10 fire with enable set same write", sw_ctrl, 8'h77);
    check("R7 trigger 2 enabled", {5'b0, trig_en}, 8'h04);
    plain_wr(SA_LO, 5'h1C, 8'h00, -1);
  endtask

  task automatic t_ignored();
    plain_wr(SA_LO, 5'h05, 8'hFF, -1);
    check("R11 other address ctrl", sw_ctrl, 8'h77);
    check("R11 other address trig", {5'b0, trig_en}, 8'h00);
    ssc();
    send_cmd(SA_LO, 8'h61, 1'b0);
    send_byte(8'h0F, 1'b0);
    bpc();
    check("R11 unsupported command", sw_ctrl, 8'h77);
  endtask

  initial begin
    clk_wait(5);
    @(negedge clk);
    rst_n = 1'b1;
    clk_wait(3);
    t_reset();
    t_direct();
    t_id();
    t_parity_start();
    t_trigger();
    t_ignored();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule